// File: doc/BRIEF.md
# Four-Way Victim Selector with Line Locking

This block chooses which way of a set-associative cache receives the next line fill. It keeps the recency order of the four ways in each of 128 sets, 512 lines of 32 bytes in total, and updates that order on every hit and every fill. Tag arrays, data arrays and bus traffic stay outside the block. The cache controller presents one operation per cycle: a hit report, a fill request, a lock command or an unlock command, each with a set index and, where it applies, a way.

For a fill, the block returns the least recently used way among the unlocked ways of that set, one cycle after the request. Software can pin individual lines by locking their way. At least one way per set must stay unlocked, so a lock that would pin the last free way is refused and reported with an error pulse. A per-access streaming flag sends a fill to way 0 so that streamed data does not displace useful lines. If way 0 of that set is locked, a streaming fill uses normal selection instead.

Top module: `lruWayPicker`

## Requirements
- R1: After reset every set has no locked way and the recency order way 0 (most recent) down to way 3 (least recent). `victimValid` and `lockErr` are low, and the first plain fill to any set returns way 3.
- R2: A fill request (`opKind` = 1) raises `victimValid` for exactly one cycle, in the cycle after the request, with the chosen way on `victimWay`. The chosen way becomes the most recently used way of its set.
- R3: A hit report (`opKind` = 0) makes `opWay` the most recently used way of the set and keeps the relative order of the other three ways.
- R4: A non-streaming fill returns the least recently used way among the unlocked ways of the set.
- R5: A locked way is never returned by a fill.
- R6: A lock command (`opKind` = 2) on an unlocked way is refused when the other three ways are already locked. A refused lock raises `lockErr` for one cycle, in the cycle after the command, and changes no state. Locking a way that is already locked changes nothing and raises no error.
- R7: An unlock command (`opKind` = 3) clears the lock of `opWay`, and that way can again be chosen by a fill. It does not change the recency order.
- R8: A fill with `opStream` high returns way 0 whenever way 0 of that set is unlocked.
- R9: A streaming fill to a set whose way 0 is locked falls back to the selection of R4.
- R10: Operations on one set leave the order and locks of every other set unchanged.
- R11: While `opValid` is low, the other operation inputs have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| opValid | input | 1 | An operation is presented this cycle |
| opKind | input | 2 | 0 hit, 1 fill, 2 lock, 3 unlock |
| opSet | input | 7 | Set index |
| opWay | input | 2 | Way for hit, lock and unlock |
| opStream | input | 1 | Streaming attribute of a fill |
| victimValid | output | 1 | Fill result valid (one cycle) |
| victimWay | output | 2 | Way chosen for the fill |
| lockErr | output | 1 | Lock refused (one cycle) |

## Verification
A corrupted recency order does not show at the ports when it happens. It shows at the next fill to the same set, which returns a way that is not the least recently used unlocked one. The bench therefore follows hits and locks with fills on the same set and compares each fill against a timestamp model. A wrong lock bit shows either as a locked way being returned by a fill or as a refused or accepted lock that the model does not expect. This appears in the cycle after the next fill or lock on that set. A long mixed sequence over a few sets catches state that drifts only after several updates.

// File: rtl/lruPkg.sv
package lruPkg;
  typedef enum logic [1:0] {
    OP_HIT    = 2'd0,
    OP_FILL   = 2'd1,
    OP_LOCK   = 2'd2,
    OP_UNLOCK = 2'd3
  } opKind_t;

  typedef struct packed {
    logic touch;    // move wrWay to most-recent rank
    logic isFill;   // touch comes from a fill
    logic setLock;  // set lock bit of wrWay
    logic clrLock;  // clear lock bit of wrWay
  } ctlStrobe_t;
endpackage

// File: rtl/lruVictimPick.sv
module lruVictimPick #(
  parameter int WAYS  = 4,
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic [WAYS-1:0][WAY_W-1:0] order,
  input  logic [WAYS-1:0]            locks,
  input  logic                       stream,
  output logic [WAY_W-1:0]           victim
);
  logic [WAY_W-1:0] lruPick;

  // Walk from most recent to least recent; the last unlocked way seen is
  // the least recently used eligible way.
  always_comb begin
    lruPick = order[WAYS-1];
    for (int r = 0; r < WAYS; r++) begin
      if (!locks[order[r]]) lruPick = order[r];
    end
  end

  assign victim = (stream && !locks[0]) ? '0 : lruPick;
endmodule

// File: rtl/lruCtrl.sv
module lruCtrl
  import lruPkg::*;
#(
  parameter int WAYS  = 4,
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       opValid,
  input  logic [1:0]                 opKind,
  input  logic [WAY_W-1:0]           opWay,
  input  logic                       opStream,
  input  logic [WAYS-1:0][WAY_W-1:0] rdOrder,
  input  logic [WAYS-1:0]            rdLocks,
  output ctlStrobe_t                 strobe,
  output logic [WAY_W-1:0]           wrWay,
  output logic                       victimValid,
  output logic [WAY_W-1:0]           victimWay,
  output logic                       lockErr
);
  opKind_t          kind;
  logic [WAY_W-1:0] pickWay;
  logic             lockRefuse;
  logic             isHit, isFill, isLock, isUnlock;
  int               lockCount;

  assign kind     = opKind_t'(opKind);
  assign isHit    = opValid && (kind == OP_HIT);
  assign isFill   = opValid && (kind == OP_FILL);
  assign isLock   = opValid && (kind == OP_LOCK);
  assign isUnlock = opValid && (kind == OP_UNLOCK);

  lruVictimPick #(.WAYS(WAYS)) uPick (
    .order  (rdOrder),
    .locks  (rdLocks),
    .stream (opStream),
    .victim (pickWay)
  );

  always_comb begin
    lockCount = 0;
    for (int w = 0; w < WAYS; w++) lockCount += int'(rdLocks[w]);
  end

  assign lockRefuse = !rdLocks[opWay] && (lockCount == WAYS - 1);

  always_comb begin
    strobe.touch   = isHit || isFill;
    strobe.isFill  = isFill;
    strobe.setLock = isLock && !lockRefuse;
    strobe.clrLock = isUnlock;
    wrWay          = isFill ? pickWay : opWay;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      victimValid <= 1'b0;
      victimWay   <= '0;
      lockErr     <= 1'b0;
    end else begin
      victimValid <= isFill;
      victimWay   <= isFill ? pickWay : victimWay;
      lockErr     <= isLock && lockRefuse;
    end
  end

  // R2
  fill_result_chk: assert property (@(posedge clk) disable iff (!rstN)
    victimValid |-> $past(opValid && opKind == 2'd1));

  // R6
  lock_err_src_chk: assert property (@(posedge clk) disable iff (!rstN)
    lockErr |-> $past(opValid && opKind == 2'd2));

  // R8
  stream_way0_chk: assert property (@(posedge clk) disable iff (!rstN)
    (victimValid && $past(opStream && !rdLocks[0])) |-> (victimWay == '0));
endmodule

// File: rtl/lruState.sv
module lruState
  import lruPkg::*;
#(
  parameter int SETS  = 128,
  parameter int WAYS  = 4,
  localparam int SET_W = $clog2(SETS),
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic [SET_W-1:0]           rdSet,
  input  ctlStrobe_t                 strobe,
  input  logic [WAY_W-1:0]           wrWay,
  output logic [WAYS-1:0][WAY_W-1:0] rdOrder,
  output logic [WAYS-1:0]            rdLocks
);
  logic [WAYS-1:0][WAY_W-1:0] orderMem [SETS];
  logic [WAYS-1:0]            lockMem  [SETS];
  logic [WAYS-1:0][WAY_W-1:0] nextOrder;
  int                         hitRank;

  assign rdOrder = orderMem[rdSet];
  assign rdLocks = lockMem[rdSet];

  // Promote wrWay to rank 0, shift the more recent ranks down by one.
  always_comb begin
    hitRank = WAYS - 1;
    for (int r = 0; r < WAYS; r++) begin
      if (rdOrder[r] == wrWay) hitRank = r;
    end
    nextOrder[0] = wrWay;
    for (int r = 1; r < WAYS; r++) begin
      nextOrder[r] = (r <= hitRank) ? rdOrder[r-1] : rdOrder[r];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int s = 0; s < SETS; s++) begin
        for (int r = 0; r < WAYS; r++) orderMem[s][r] <= WAY_W'(r);
        lockMem[s] <= '0;
      end
    end else begin
      if (strobe.touch) orderMem[rdSet] <= nextOrder;
      if (strobe.setLock) lockMem[rdSet][wrWay] <= 1'b1;
      else if (strobe.clrLock) lockMem[rdSet][wrWay] <= 1'b0;
    end
  end

  // R5
  fill_unlocked_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.touch && strobe.isFill) |-> !rdLocks[wrWay]);

  // R6
  one_way_free_chk: assert property (@(posedge clk) disable iff (!rstN)
    $countones(rdLocks) < WAYS);

  // R3
  generate
    for (genvar i = 0; i < WAYS; i++) begin : gOrdI
      for (genvar j = i + 1; j < WAYS; j++) begin : gOrdJ
        order_perm_chk: assert property (@(posedge clk) disable iff (!rstN)
          rdOrder[i] != rdOrder[j]);
      end
    end
  endgenerate
endmodule

// File: rtl/lruWayPicker.sv
module lruWayPicker
  import lruPkg::*;
#(
  parameter int SETS  = 128,
  parameter int WAYS  = 4,
  localparam int SET_W = $clog2(SETS),
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             opValid,
  input  logic [1:0]       opKind,
  input  logic [SET_W-1:0] opSet,
  input  logic [WAY_W-1:0] opWay,
  input  logic             opStream,
  output logic             victimValid,
  output logic [WAY_W-1:0] victimWay,
  output logic             lockErr
);
  ctlStrobe_t                 strobe;
  logic [WAY_W-1:0]           wrWay;
  logic [WAYS-1:0][WAY_W-1:0] rdOrder;
  logic [WAYS-1:0]            rdLocks;

  lruCtrl #(.WAYS(WAYS)) uCtrl (
    .clk         (clk),
    .rstN        (rstN),
    .opValid     (opValid),
    .opKind      (opKind),
    .opWay       (opWay),
    .opStream    (opStream),
    .rdOrder     (rdOrder),
    .rdLocks     (rdLocks),
    .strobe      (strobe),
    .wrWay       (wrWay),
    .victimValid (victimValid),
    .victimWay   (victimWay),
    .lockErr     (lockErr)
  );

  lruState #(.SETS(SETS), .WAYS(WAYS)) uState (
    .clk     (clk),
    .rstN    (rstN),
    .rdSet   (opSet),
    .strobe  (strobe),
    .wrWay   (wrWay),
    .rdOrder (rdOrder),
    .rdLocks (rdLocks)
  );
endmodule

// File: tb/sim_lruWayPicker.sv
module sim_lruWayPicker;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       opValid = 1'b0;
  logic [1:0] opKind = 2'd0;
  logic [6:0] opSet = '0;
  logic [1:0] opWay = '0;
  logic       opStream = 1'b0;
  logic       victimValid;
  logic [1:0] victimWay;
  logic       lockErr;

  int checks = 0;
  int fails = 0;
  int now = 0;
  int ts [128][4];
  bit lk [128][4];
  bit done = 1'b0;

  always #10 clk = ~clk;

  lruWayPicker u0 (
    .clk(clk), .rstN(rstN), .opValid(opValid), .opKind(opKind),
    .opSet(opSet), .opWay(opWay), .opStream(opStream),
    .victimValid(victimValid), .victimWay(victimWay), .lockErr(lockErr)
  );

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int modelFill(int s, bit strm);
    int best = -1;
    if (strm && !lk[s][0]) best = 0;
    else begin
      for (int w = 0; w < 4; w++)
        if (!lk[s][w] && (best < 0 || ts[s][w] < ts[s][best])) best = w;
    end
    now++;
    ts[s][best] = now;
    return best;
  endfunction

  // Presents one operation, then samples the registered results.
  task automatic runOp(int kind, int s, int w, bit strm, bit vld,
                       output bit vv, output int vw, output bit le);
    @(negedge clk);
    opValid = vld; opKind = 2'(kind); opSet = 7'(s);
    opWay = 2'(w); opStream = strm;
    @(negedge clk);
    vv = victimValid; vw = int'(victimWay); le = lockErr;
    opValid = 1'b0;
  endtask

  task automatic fillChk(string req, int s, bit strm);
    bit vv, le; int vw, exp;
    exp = modelFill(s, strm);
    runOp(1, s, 0, strm, 1'b1, vv, vw, le);
    chk({req, " valid"}, int'(vv), 1);
    chk({req, " way"}, vw, exp);
  endtask

  task automatic hitOp(int s, int w);
    bit vv, le; int vw;
    now++; ts[s][w] = now;
    runOp(0, s, w, 1'b0, 1'b1, vv, vw, le);
    chk("R2 no result on hit", int'(vv), 0);
  endtask

  task automatic lockOp(string req, int s, int w);
    bit vv, le; int vw, cnt; bit expErr;
    cnt = 0;
    for (int i = 0; i < 4; i++) cnt += int'(lk[s][i]);
    expErr = !lk[s][w] && cnt == 3;
    if (!expErr) lk[s][w] = 1'b1;
    runOp(2, s, w, 1'b0, 1'b1, vv, vw, le);
    chk(req, int'(le), int'(expErr));
  endtask

  task automatic unlockOp(int s, int w);
    bit vv, le; int vw;
    lk[s][w] = 1'b0;
    runOp(3, s, w, 1'b0, 1'b1, vv, vw, le);
    chk("R7 no error on unlock", int'(le), 0);
  endtask

  task automatic testReset();
    chk("R1 victimValid at reset", int'(victimValid), 0);
    chk("R1 lockErr at reset", int'(lockErr), 0);
    fillChk("R1 first fill", 5, 1'b0);
    @(negedge clk);
    chk("R2 valid is one cycle", int'(victimValid), 0);
  endtask

  task automatic testLru();
    for (int i = 0; i < 4; i++) fillChk("R4 rotation", 10, 1'b0);
    hitOp(10, 3);
    hitOp(10, 1);
    fillChk("R3 after hits", 10, 1'b0);
    fillChk("R3 after hits second", 10, 1'b0);
  endtask

  task automatic testLock();
    lockOp("R6 lock accepted", 20, 3);
    fillChk("R5 locked way skipped", 20, 1'b0);
    lockOp("R6 lock accepted", 20, 2);
    lockOp("R6 lock accepted", 20, 1);
    lockOp("R6 fourth lock refused", 20, 0);
    lockOp("R6 relock no error", 20, 1);
    fillChk("R6 refused lock left way 0 free", 20, 1'b0);
    fillChk("R5 only free way", 20, 1'b0);
    unlockOp(20, 3);
    fillChk("R7 unlocked way eligible", 20, 1'b0);
  endtask

  task automatic testStream();
    fillChk("R8 stream to way 0", 30, 1'b1);
    fillChk("R8 stream again", 30, 1'b1);
    lockOp("R9 lock way 0", 30, 0);
    fillChk("R9 stream fallback", 30, 1'b1);
    fillChk("R9 stream fallback second", 30, 1'b1);
  endtask

  task automatic testIdle();
    bit vv, le; int vw;
    runOp(1, 40, 0, 1'b0, 1'b0, vv, vw, le);
    chk("R11 idle fill no result", int'(vv), 0);
    runOp(2, 41, 0, 1'b0, 1'b0, vv, vw, le);
    fillChk("R11 idle ops left state", 40, 1'b0);
    fillChk("R11 idle lock left state", 41, 1'b1);
  endtask

  task automatic testSets();
    fillChk("R10 untouched set 127", 127, 1'b0);
    fillChk("R10 untouched set 0", 0, 1'b0);
  endtask

  task automatic testMixed();
    bit vv, le; int vw, k, s, w; bit st;
    for (int n = 0; n < 400; n++) begin
      k = $urandom_range(0, 3);
      s = 60 + $urandom_range(0, 2);
      w = $urandom_range(0, 3);
      st = 1'($urandom_range(0, 1));
      case (k)
        0: hitOp(s, w);
        1: fillChk("R4 mixed fill", s, st);
        2: lockOp("R6 mixed lock", s, w);
        default: unlockOp(s, w);
      endcase
    end
  endtask

  initial begin
    for (int s = 0; s < 128; s++)
      for (int w = 0; w < 4; w++) begin ts[s][w] = -w; lk[s][w] = 1'b0; end
    void'($urandom(7));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testLru();
    testLock();
    testStream();
    testIdle();
    testSets();
    testMixed();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    #(20 * 100000);
    if (!done) begin
      done = 1'b1;
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule